// File: doc/BRIEF.md
# Multi-Agent Interrupt Destination Router

This block sits on a shared interrupt message path in front of a set of local interrupt agents. Each message carries a vector, an 8-bit destination, a delivery mode, a destination mode (physical or logical), a trigger mode, an assert/deassert level bit, a destination shorthand and the index of the sending agent. The router uses these fields, together with live status from every agent (its physical ID, whether its logical-destination compare matches, its arbitration priority and a focus flag), to decide which agents receive the message.

Physical addressing selects one agent by ID or, with the all-ones destination, every agent. Logical addressing selects every agent whose logical compare matches. Lowest-priority delivery narrows the selected set to a single agent: an agent that already holds the vector with focus enabled is preferred, and otherwise the one with the smallest arbitration priority wins. Shorthands address the sender itself, every agent, or every agent except the sender without looking at the destination.

The result is registered: one cycle after a message is sampled, the router pulses a per-agent deliver strobe together with the vector, mode and trigger, a response-valid flag and an accepted flag. A message that reaches nobody raises a one-cycle transmit-error strobe toward the sending agent. The agent count is a parameter (default 4).

Top module: `ir_dest_router`

## Requirements
- R1: A message sampled with `msg_valid` high at a rising edge produces its result on every output during the following cycle only; `rsp_valid` pulses once per message, and a cycle without a message leaves `dlv_strobe`, `rsp_valid`, `rsp_accepted` and `tx_err` at zero. All outputs are zero in reset.
- R2: With shorthand 0 (bits `msg_short` = 2'b00), physical mode (`msg_logical`=0) and a non-lowest-priority mode, a destination other than 8'hFF strobes only the lowest-indexed agent whose ID equals it; if no ID equals it, no agent is strobed and `rsp_accepted` is 0. `rsp_accepted` is 1 exactly when at least one strobe bit is set.
- R3: With shorthand 0, physical mode and destination 8'hFF, a non-lowest-priority message strobes every agent.
- R4: With shorthand 0 and logical mode, destination 8'h00 strobes no agent and is not accepted (in any delivery mode); any other destination in a non-lowest-priority mode strobes exactly the agents whose `agent_match` bit is set.
- R5: Lowest-priority mode (`msg_mode` = 3'b001) with shorthand 0 in physical mode is dropped: no strobe, not accepted.
- R6: In lowest-priority mode the router strobes a single agent; if any candidate agent has its `agent_focus` bit set, the lowest-indexed such candidate is chosen, even when another candidate has a smaller priority.
- R7: In lowest-priority mode with no focused candidate, the candidate with the numerically smallest `agent_prio` is chosen; on equal priority the lowest index wins. With shorthand 0 in logical mode the candidates are the agents with `agent_match` set.
- R8: Shorthand 1 strobes only the agent numbered `msg_src`, in any delivery mode, and is always accepted; destination and destination mode are ignored.
- R9: Shorthand 2 addresses every agent and shorthand 3 every agent except `msg_src`; in lowest-priority mode that set becomes the candidate set of R6/R7 instead of being strobed in full.
- R10: When a message is not accepted (other than by R11), `tx_err` carries a one-hot pulse at bit `msg_src` in the same cycle as `rsp_valid`; otherwise `tx_err` is zero.
- R11: An INIT message (`msg_mode` = 3'b101) with level trigger (`msg_level`=1) and `msg_assert`=0 is discarded: no strobe, not accepted, and no `tx_err`. With `msg_assert`=1 it is routed normally.
- R12: Whenever `rsp_valid` is high, `dlv_vector`, `dlv_mode` and `dlv_level` equal the vector, delivery mode and trigger mode of the message sampled one cycle earlier. Mode codes: 000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT, 110 start-up, 111 external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_vector | input | VEC_W | Interrupt vector |
| msg_dest | input | ID_W | Destination field |
| msg_mode | input | 3 | Delivery mode code |
| msg_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| msg_level | input | 1 | Trigger mode, 1 = level |
| msg_assert | input | 1 | Level bit, 1 = assert |
| msg_short | input | 2 | Shorthand: 0 destination, 1 self, 2 all, 3 all but self |
| msg_src | input | SRC_W | Index of the sending agent |
| agent_id | input | N_AGENTS*ID_W | Physical ID of each agent, agent 0 in the low bits |
| agent_match | input | N_AGENTS | Logical destination compare result per agent |
| agent_prio | input | N_AGENTS*PRIO_W | Arbitration priority per agent |
| agent_focus | input | N_AGENTS | Agent holds this vector with focus enabled |
| dlv_strobe | output | N_AGENTS | Deliver strobe per agent |
| dlv_vector | output | VEC_W | Vector delivered |
| dlv_mode | output | 3 | Delivery mode delivered |
| dlv_level | output | 1 | Trigger mode delivered |
| rsp_valid | output | 1 | Result of a message is on the outputs |
| rsp_accepted | output | 1 | At least one agent was strobed |
| tx_err | output | N_AGENTS | One-hot send-accept error toward the sender |

## Verification
Every result of this block is due exactly one clock edge after the edge that sampled `msg_valid`: strobes, echoed fields, the accepted flag and the error pulse all come from the same register stage, and all return to zero one further edge later. The bench drives a message on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge, half a cycle after they settled; a back-to-back pair checks that consecutive messages each appear in their own cycle and that the idle cycle after them is quiet.

// File: rtl/ir_pkg.sv
package ir_pkg;

    // Delivery mode codes; the agents decode this field.
    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_START  = 3'b110,
        DM_EXTERN = 3'b111
    } dmode_e;

    // Destination shorthand codes.
    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

endpackage

// File: rtl/ir_dest_decode.sv
// Turns the addressing fields of one message into either a direct
// delivery set or a candidate set for lowest-priority arbitration.
module ir_dest_decode
    import ir_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 8,
    parameter int SRC_W    = 2
) (
    input  logic [ID_W-1:0]          msg_dest,
    input  logic [2:0]               msg_mode,
    input  logic                     msg_logical,
    input  logic                     msg_level,
    input  logic                     msg_assert,
    input  logic [1:0]               msg_short,
    input  logic [SRC_W-1:0]         msg_src,
    input  logic [N_AGENTS*ID_W-1:0] agent_id,
    input  logic [N_AGENTS-1:0]      agent_match,
    output logic [N_AGENTS-1:0]      direct_mask,
    output logic [N_AGENTS-1:0]      cand_mask,
    output logic                     need_arb,
    output logic                     silent_drop,
    output logic [N_AGENTS-1:0]      self_mask
);

    localparam logic [N_AGENTS-1:0] ONE_HOT0 = {{(N_AGENTS-1){1'b0}}, 1'b1};
    localparam logic [N_AGENTS-1:0] ALL_MASK = '1;
    localparam logic [ID_W-1:0]     BCAST_ID = '1;

    logic [N_AGENTS-1:0] id_eq;
    logic [N_AGENTS-1:0] phys_hit;
    logic                is_lowpri;
    logic                init_deassert;

    // Per-agent physical ID compare.
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_id_cmp
        assign id_eq[g] = (agent_id[g*ID_W +: ID_W] == msg_dest);
    end

    // Keep only the lowest-indexed ID hit: a physical address names one agent.
    always_comb begin
        phys_hit = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (id_eq[i]) begin
                phys_hit = ONE_HOT0 << i;
            end
        end
    end

    assign self_mask     = ONE_HOT0 << msg_src;
    assign is_lowpri     = (msg_mode == DM_LOWPRI);
    assign init_deassert = (msg_mode == DM_INIT) && msg_level && !msg_assert;

    always_comb begin
        direct_mask = '0;
        cand_mask   = '0;
        need_arb    = 1'b0;
        silent_drop = 1'b0;
        if (init_deassert) begin
            silent_drop = 1'b1;
        end else begin
            unique case (shorthand_e'(msg_short))
                SH_SELF: begin
                    direct_mask = self_mask;
                end
                SH_ALL: begin
                    if (is_lowpri) begin
                        cand_mask = ALL_MASK;
                        need_arb  = 1'b1;
                    end else begin
                        direct_mask = ALL_MASK;
                    end
                end
                SH_OTHERS: begin
                    if (is_lowpri) begin
                        cand_mask = ALL_MASK & ~self_mask;
                        need_arb  = 1'b1;
                    end else begin
                        direct_mask = ALL_MASK & ~self_mask;
                    end
                end
                default: begin
                    if (!msg_logical) begin
                        // Lowest priority has no meaning for a physical ID.
                        if (!is_lowpri) begin
                            direct_mask = (msg_dest == BCAST_ID) ? ALL_MASK : phys_hit;
                        end
                    end else if (msg_dest != '0) begin
                        if (is_lowpri) begin
                            cand_mask = agent_match;
                            need_arb  = 1'b1;
                        end else begin
                            direct_mask = agent_match;
                        end
                    end
                end
            endcase
        end
    end

    // R11: a discarded message never produces a target set
    always_comb begin
        a_r11_drop_no_target: assert (!silent_drop || (direct_mask == '0 && cand_mask == '0));
    end

endmodule

// File: rtl/ir_lowpri_pick.sv
// Lowest-priority selection: focused candidate first, then the
// candidate with the smallest arbitration priority (lowest index on ties).
module ir_lowpri_pick #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8
) (
    input  logic [N_AGENTS-1:0]        cand,
    input  logic [N_AGENTS-1:0]        focus,
    input  logic [N_AGENTS*PRIO_W-1:0] prio,
    output logic [N_AGENTS-1:0]        pick
);

    localparam int SRC_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
    localparam logic [N_AGENTS-1:0] ONE_HOT0 = {{(N_AGENTS-1){1'b0}}, 1'b1};

    logic [N_AGENTS-1:0] focus_cand;
    logic [N_AGENTS-1:0] focus_pick;
    logic [PRIO_W-1:0]   best_prio;
    logic [SRC_W-1:0]    best_idx;
    logic                have_best;

    assign focus_cand = cand & focus;

    // Lowest-indexed focused candidate.
    always_comb begin
        focus_pick = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (focus_cand[i]) begin
                focus_pick = ONE_HOT0 << i;
            end
        end
    end

    // Linear minimum search; strict compare keeps the lower index on ties.
    always_comb begin
        best_prio = '1;
        best_idx  = '0;
        have_best = 1'b0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (cand[i] && (!have_best || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                best_prio = prio[i*PRIO_W +: PRIO_W];
                best_idx  = SRC_W'(i);
                have_best = 1'b1;
            end
        end
    end

    always_comb begin
        if (focus_cand != '0) begin
            pick = focus_pick;
        end else if (have_best) begin
            pick = ONE_HOT0 << best_idx;
        end else begin
            pick = '0;
        end
    end

    // R7: the winner is always one of the candidates, and there is at most one
    always_comb begin
        a_r7_pick_in_cand: assert (((pick & ~cand) == '0) && $onehot0(pick));
    end

endmodule

// File: rtl/ir_dest_router.sv
module ir_dest_router
    import ir_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 8,
    parameter int VEC_W    = 8,
    parameter int PRIO_W   = 8,
    localparam int SRC_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    input  logic [VEC_W-1:0]           msg_vector,
    input  logic [ID_W-1:0]            msg_dest,
    input  logic [2:0]                 msg_mode,
    input  logic                       msg_logical,
    input  logic                       msg_level,
    input  logic                       msg_assert,
    input  logic [1:0]                 msg_short,
    input  logic [SRC_W-1:0]           msg_src,
    input  logic [N_AGENTS*ID_W-1:0]   agent_id,
    input  logic [N_AGENTS-1:0]        agent_match,
    input  logic [N_AGENTS*PRIO_W-1:0] agent_prio,
    input  logic [N_AGENTS-1:0]        agent_focus,
    output logic [N_AGENTS-1:0]        dlv_strobe,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [2:0]                 dlv_mode,
    output logic                       dlv_level,
    output logic                       rsp_valid,
    output logic                       rsp_accepted,
    output logic [N_AGENTS-1:0]        tx_err
);

    typedef struct packed {
        logic [N_AGENTS-1:0] strobe;
        logic [VEC_W-1:0]    vector;
        logic [2:0]          mode;
        logic                level;
        logic                valid;
        logic                accepted;
        logic [N_AGENTS-1:0] err;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [N_AGENTS-1:0] direct_mask;
    logic [N_AGENTS-1:0] cand_mask;
    logic [N_AGENTS-1:0] self_mask;
    logic [N_AGENTS-1:0] arb_pick;
    logic                need_arb;
    logic                silent_drop;
    logic [N_AGENTS-1:0] target;
    logic                hit_any;

    ir_dest_decode #(
        .N_AGENTS (N_AGENTS),
        .ID_W     (ID_W),
        .SRC_W    (SRC_W)
    ) u_decode (
        .msg_dest    (msg_dest),
        .msg_mode    (msg_mode),
        .msg_logical (msg_logical),
        .msg_level   (msg_level),
        .msg_assert  (msg_assert),
        .msg_short   (msg_short),
        .msg_src     (msg_src),
        .agent_id    (agent_id),
        .agent_match (agent_match),
        .direct_mask (direct_mask),
        .cand_mask   (cand_mask),
        .need_arb    (need_arb),
        .silent_drop (silent_drop),
        .self_mask   (self_mask)
    );

    ir_lowpri_pick #(
        .N_AGENTS (N_AGENTS),
        .PRIO_W   (PRIO_W)
    ) u_pick (
        .cand  (cand_mask),
        .focus (agent_focus),
        .prio  (agent_prio),
        .pick  (arb_pick)
    );

    assign target  = direct_mask | (need_arb ? arb_pick : '0);
    assign hit_any = (target != '0);

    // Next-state computation.
    always_comb begin
        st_d = '0;
        if (msg_valid) begin
            st_d.strobe   = target;
            st_d.vector   = msg_vector;
            st_d.mode     = msg_mode;
            st_d.level    = msg_level;
            st_d.valid    = 1'b1;
            st_d.accepted = hit_any;
            st_d.err      = (!hit_any && !silent_drop) ? self_mask : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlv_strobe   = st_q.strobe;
    assign dlv_vector   = st_q.vector;
    assign dlv_mode     = st_q.mode;
    assign dlv_level    = st_q.level;
    assign rsp_valid    = st_q.valid;
    assign rsp_accepted = st_q.accepted;
    assign tx_err       = st_q.err;

    // R1: every sampled message yields a response one cycle later
    a_r1_rsp_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> rsp_valid);

    // R1: idle cycles leave the outputs quiet
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> (dlv_strobe == '0 && !rsp_valid && tx_err == '0));

    // R2: accepted flag agrees with the strobes
    a_r2_accept_tracks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_accepted == (dlv_strobe != '0)));

    // R6: lowest-priority delivery reaches at most one agent
    a_r6_lowpri_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && dlv_mode == DM_LOWPRI) |-> $onehot0(dlv_strobe));

    // R10: the error pulse is one-hot and only on a rejected message
    a_r10_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err != '0) |-> (rsp_valid && !rsp_accepted && $onehot(tx_err)));

    // R11: an INIT deassert produces neither strobe nor error
    a_r11_init_deassert_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_mode == DM_INIT && msg_level && !msg_assert)
            |=> (dlv_strobe == '0 && tx_err == '0 && rsp_valid));

endmodule

// File: tb/ir_dest_router_tb.sv
module ir_dest_router_tb;

    localparam int N  = 4;
    localparam int NV = 26;
    localparam logic [31:0] PD = 32'h20302040; // a3=20 a2=30 a1=20 a0=40

    typedef struct packed {
        logic [7:0]  rq;
        logic [1:0]  sh;
        logic        lg;
        logic [2:0]  md;
        logic [7:0]  dst;
        logic [1:0]  src;
        logic [7:0]  vec;
        logic        lvl;
        logic        ast;
        logic [3:0]  mt;
        logic [3:0]  fc;
        logic [31:0] pr;
        logic [3:0]  xs;
        logic        xa;
        logic [3:0]  xe;
    } vec_t;

    // Agent IDs fixed for the table: a0=10 a1=11 a2=12 a3=11
    localparam vec_t VTAB [NV] = '{
        '{8'd2, 2'd0,1'b0,3'd0,8'h12,2'd2,8'h41,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0100,1'b1,4'b0000}, // R2 single id
        '{8'd2, 2'd0,1'b0,3'd0,8'h11,2'd0,8'h42,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0010,1'b1,4'b0000}, // R2 duplicate id
        '{8'd2, 2'd0,1'b0,3'd0,8'h33,2'd2,8'h43,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0000,1'b0,4'b0100}, // R2 no id, R10
        '{8'd3, 2'd0,1'b0,3'd0,8'hFF,2'd0,8'h44,1'b0,1'b1,4'b0000,4'b0000,PD,4'b1111,1'b1,4'b0000}, // R3 broadcast
        '{8'd4, 2'd0,1'b1,3'd0,8'h05,2'd0,8'h45,1'b1,1'b1,4'b1010,4'b0000,PD,4'b1010,1'b1,4'b0000}, // R4 logical
        '{8'd4, 2'd0,1'b1,3'd0,8'h00,2'd0,8'h46,1'b0,1'b1,4'b1010,4'b0000,PD,4'b0000,1'b0,4'b0001}, // R4 dest zero
        '{8'd5, 2'd0,1'b0,3'd1,8'h10,2'd1,8'h47,1'b0,1'b1,4'b1111,4'b0000,PD,4'b0000,1'b0,4'b0010}, // R5 lowpri physical
        '{8'd6, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h48,1'b0,1'b1,4'b1111,4'b0100,PD,4'b0100,1'b1,4'b0000}, // R6 focus beats prio
        '{8'd6, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h49,1'b0,1'b1,4'b1111,4'b1100,PD,4'b0100,1'b1,4'b0000}, // R6 lowest focus idx
        '{8'd6, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h4A,1'b0,1'b1,4'b1110,4'b0001,PD,4'b0010,1'b1,4'b0000}, // R6 focus not cand
        '{8'd7, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h4B,1'b0,1'b1,4'b1111,4'b0000,PD,4'b0010,1'b1,4'b0000}, // R7 tie low idx
        '{8'd7, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h4C,1'b0,1'b1,4'b1101,4'b0000,PD,4'b1000,1'b1,4'b0000}, // R7 subset
        '{8'd7, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h4D,1'b0,1'b1,4'b0101,4'b0000,PD,4'b0100,1'b1,4'b0000}, // R7 min of two
        '{8'd4, 2'd0,1'b1,3'd1,8'h00,2'd3,8'h4E,1'b0,1'b1,4'b1111,4'b0000,PD,4'b0000,1'b0,4'b1000}, // R4 lowpri dest zero
        '{8'd8, 2'd1,1'b0,3'd0,8'h10,2'd3,8'h4F,1'b0,1'b1,4'b0000,4'b0000,PD,4'b1000,1'b1,4'b0000}, // R8 self
        '{8'd8, 2'd1,1'b0,3'd1,8'h10,2'd0,8'h50,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0001,1'b1,4'b0000}, // R8 self lowpri
        '{8'd9, 2'd2,1'b0,3'd0,8'h00,2'd0,8'h51,1'b0,1'b1,4'b0000,4'b0000,PD,4'b1111,1'b1,4'b0000}, // R9 all
        '{8'd9, 2'd3,1'b0,3'd0,8'h00,2'd1,8'h52,1'b0,1'b1,4'b0000,4'b0000,PD,4'b1101,1'b1,4'b0000}, // R9 all but self
        '{8'd9, 2'd2,1'b0,3'd1,8'h00,2'd0,8'h53,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0010,1'b1,4'b0000}, // R9 all lowpri
        '{8'd9, 2'd3,1'b0,3'd1,8'h00,2'd1,8'h54,1'b0,1'b1,4'b0000,4'b0000,PD,4'b1000,1'b1,4'b0000}, // R9 others lowpri
        '{8'd11,2'd0,1'b0,3'd5,8'hFF,2'd0,8'h55,1'b1,1'b0,4'b0000,4'b0000,PD,4'b0000,1'b0,4'b0000}, // R11 init deassert
        '{8'd11,2'd0,1'b0,3'd5,8'hFF,2'd0,8'h56,1'b1,1'b1,4'b0000,4'b0000,PD,4'b1111,1'b1,4'b0000}, // R11 init assert
        '{8'd12,2'd0,1'b1,3'd4,8'h07,2'd2,8'h57,1'b1,1'b1,4'b0110,4'b0000,PD,4'b0110,1'b1,4'b0000}, // R12 nmi echo
        '{8'd9, 2'd2,1'b0,3'd1,8'h00,2'd0,8'h58,1'b0,1'b1,4'b0000,4'b1000,PD,4'b1000,1'b1,4'b0000}, // R9 focus in all
        '{8'd10,2'd0,1'b0,3'd0,8'h20,2'd1,8'h59,1'b0,1'b1,4'b0000,4'b0000,PD,4'b0000,1'b0,4'b0010}, // R10 error to src
        '{8'd7, 2'd0,1'b1,3'd1,8'h0F,2'd0,8'h5A,1'b0,1'b1,4'b1111,4'b0000,32'h05302040,4'b1000,1'b1,4'b0000} // R7 other prio
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           msg_valid = 1'b0;
    logic [7:0]     msg_vector = '0;
    logic [7:0]     msg_dest = '0;
    logic [2:0]     msg_mode = '0;
    logic           msg_logical = 1'b0;
    logic           msg_level = 1'b0;
    logic           msg_assert = 1'b1;
    logic [1:0]     msg_short = '0;
    logic [1:0]     msg_src = '0;
    logic [N*8-1:0] agent_id = {8'h11, 8'h12, 8'h11, 8'h10};
    logic [N-1:0]   agent_match = '0;
    logic [N*8-1:0] agent_prio = PD;
    logic [N-1:0]   agent_focus = '0;
    logic [N-1:0]   dlv_strobe;
    logic [7:0]     dlv_vector;
    logic [2:0]     dlv_mode;
    logic           dlv_level;
    logic           rsp_valid;
    logic           rsp_accepted;
    logic [N-1:0]   tx_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ir_dest_router #(.N_AGENTS(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .msg_valid    (msg_valid),
        .msg_vector   (msg_vector),
        .msg_dest     (msg_dest),
        .msg_mode     (msg_mode),
        .msg_logical  (msg_logical),
        .msg_level    (msg_level),
        .msg_assert   (msg_assert),
        .msg_short    (msg_short),
        .msg_src      (msg_src),
        .agent_id     (agent_id),
        .agent_match  (agent_match),
        .agent_prio   (agent_prio),
        .agent_focus  (agent_focus),
        .dlv_strobe   (dlv_strobe),
        .dlv_vector   (dlv_vector),
        .dlv_mode     (dlv_mode),
        .dlv_level    (dlv_level),
        .rsp_valid    (rsp_valid),
        .rsp_accepted (rsp_accepted),
        .tx_err       (tx_err)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        msg_valid   = 1'b1;
        msg_short   = v.sh;
        msg_logical = v.lg;
        msg_mode    = v.md;
        msg_dest    = v.dst;
        msg_src     = v.src;
        msg_vector  = v.vec;
        msg_level   = v.lvl;
        msg_assert  = v.ast;
        agent_match = v.mt;
        agent_focus = v.fc;
        agent_prio  = v.pr;
    endtask

    task automatic expect_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.rq);
        chk(tag, "strobe", 32'(dlv_strobe), 32'(v.xs));
        chk(tag, "accepted", 32'(rsp_accepted), 32'(v.xa));
        chk(tag, "tx_err", 32'(tx_err), 32'(v.xe));
        // R12: fields echoed with the response
        chk(tag, "echo", {19'd0, rsp_valid, dlv_level, dlv_mode, dlv_vector},
            {19'd0, 1'b1, v.lvl, v.md, v.vec});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, NV * 4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset strobe", 32'(dlv_strobe), 32'd0);
        chk("R1", "reset valid", {30'd0, rsp_valid, rsp_accepted}, 32'd0);
        chk("R1", "reset err", 32'(tx_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {27'd0, rsp_valid, tx_err}, 32'd0);

        // Table walk: drive on a falling edge, check one full cycle later.
        for (int i = 0; i < NV; i++) begin
            drive(VTAB[i]);
            @(negedge clk);
            msg_valid = 1'b0;
            expect_vec(VTAB[i]);
        end

        // R1: the response lasts one cycle only
        @(negedge clk);
        chk("R1", "response cleared", {27'd0, rsp_valid, dlv_strobe}, 32'd0);

        // R1: back-to-back messages, each in its own cycle
        drive('{8'd1,2'd0,1'b0,3'd0,8'h10,2'd0,8'h60,1'b0,1'b1,4'b0,4'b0,PD,4'b0001,1'b1,4'b0});
        @(negedge clk);
        chk("R1", "first of pair", 32'(dlv_strobe), 32'h1);
        chk("R1", "first vector", 32'(dlv_vector), 32'h60);
        drive('{8'd1,2'd2,1'b0,3'd0,8'h00,2'd0,8'h61,1'b0,1'b1,4'b0,4'b0,PD,4'b1111,1'b1,4'b0});
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R1", "second of pair", 32'(dlv_strobe), 32'hF);
        chk("R1", "second vector", 32'(dlv_vector), 32'h61);
        @(negedge clk);
        chk("R1", "quiet after pair", {26'd0, rsp_valid, rsp_accepted, tx_err}, 32'd0);

        // R1: changing agent status without a message has no effect
        agent_match = 4'b1111;
        agent_focus = 4'b1111;
        @(negedge clk);
        chk("R1", "status only", {27'd0, rsp_valid, dlv_strobe}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule